// File: doc/BRIEF.md
# Buffered-Divisor Serial Baud Generator

This block derives the timing pulses that a UART-style serial transmitter and receiver need from the bus clock. Software holds a 13-bit modulo divisor in two byte-wide registers. A prescale counter emits a one-cycle oversample pulse every `divisor` bus cycles, and a 16-phase counter turns every sixteenth oversample pulse into a bit-rate pulse. The bit rate is therefore the bus clock divided by 16 times the divisor.

The divisor is loaded coherently. A write to the upper register only stages its bits. The working divisor takes the staged upper bits and the new lower byte together, in the cycle the lower register is written, so a half-updated divisor never drives the counters. The counters run only while the receiver or the transmitter is enabled and the divisor is non-zero. Otherwise they are held at zero and no pulse appears, which saves power. When counting resumes, the counters start from zero. A divisor that shrinks below the prescale count wraps the count at once, so no period is ever stretched.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset the upper readback `rdHi` is 0x00, the lower readback `rdLo` is 0x04 (working divisor 4), and neither tick pulses while both enables are 0.
- R2: A write to the upper register does not change either readback. The next write to the lower register sets the working divisor to {staged upper bits, written byte} in one step, and both readbacks show it from the following cycle.
- R3: `rdHi` bits 7:5 always read 0, and `rdHi` bits 4:0 hold divisor bits 12:8. After writing 0xFF to the upper register and then writing the lower register, `rdHi` reads 0x1F.
- R4: While `rxEn` and `txEn` are both 0, `ovsTick` and `bitTick` stay 0.
- R5: With a working divisor of 0, no tick pulses even while an enable is 1.
- R6: With divisor D (1 to 8191) and an enable held high, `ovsTick` pulses once every D bus cycles. For D ≥ 2 each pulse lasts exactly one cycle, and at D = 1 it is high on every cycle.
- R7: `bitTick` pulses only in a cycle where `ovsTick` is also high, once every 16 oversample pulses.
- R8: When an enable rises after both enables were 0, the counters start from zero. If the enable is first sampled at clock edge k, the first `ovsTick` is high after edge k+D-1, and the first `bitTick` comes with the 16th oversample pulse.
- R9: If the working divisor is lowered to a value at or below the current prescale count, the count wraps at the next edge, producing an `ovsTick`. Later pulses follow the new period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| wrData | input | 8 | Register write data |
| wrHi | input | 1 | Write strobe, upper divisor register (staged) |
| wrLo | input | 1 | Write strobe, lower divisor register (commits the divisor) |
| rxEn | input | 1 | Receiver enable |
| txEn | input | 1 | Transmitter enable |
| rdHi | output | 8 | Readback of working divisor bits 12:8, upper bits zero |
| rdLo | output | 8 | Readback of working divisor bits 7:0 |
| ovsTick | output | 1 | One-cycle oversample pulse |
| bitTick | output | 1 | One-cycle bit-rate pulse |

## Verification
The bench builds the block with its default parameters: a 13-bit divisor split over 8-bit registers, and 16 phases per bit. Small divisors (1, 2, 5) bring whole bit periods and the restart from zero within a few hundred cycles. The full-scale divisor 8191 is reached by timing single oversample periods only. A shrink from 20 to 3 in the middle of a count shows the immediate wrap.

// File: rtl/baud_pkg.sv
package baud_pkg;
  // Strobes from the register control to the counting datapath
  typedef struct packed {
    logic count;  // advance the prescale and phase counters
    logic clear;  // hold both counters at zero
  } cnt_ctl_t;
endpackage

// File: rtl/baud_ctrl.sv
module baud_ctrl
  import baud_pkg::*;
#(
  parameter int DIV_W   = 13,
  parameter int BYTE_W  = 8,
  parameter int RST_DIV = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              wrHi,
  input  logic              wrLo,
  input  logic              rxEn,
  input  logic              txEn,
  output logic [DIV_W-1:0]  divWork,
  output cnt_ctl_t          ctl,
  output logic [BYTE_W-1:0] rdHi,
  output logic [BYTE_W-1:0] rdLo
);
  localparam int HI_W  = DIV_W - BYTE_W;
  localparam int PAD_W = 2 * BYTE_W - DIV_W;

  logic [BYTE_W-1:0] stageByte;
  logic              anyEn;
  logic              divZero;

  // Upper byte is staged; the working divisor changes only on a lower write
  always_ff @(posedge clk) begin
    if (rst) begin
      stageByte <= '0;
      divWork   <= DIV_W'(RST_DIV);
    end else begin
      if (wrLo) divWork <= DIV_W'({stageByte, wrData});
      if (wrHi) stageByte <= wrData;
    end
  end

  assign anyEn     = rxEn | txEn;
  assign divZero   = (divWork == '0);
  assign ctl.count = anyEn & ~divZero;
  assign ctl.clear = ~(anyEn & ~divZero);

  assign rdLo = divWork[BYTE_W-1:0];
  generate
    if (PAD_W > 0) begin : g_pad
      assign rdHi = {{PAD_W{1'b0}}, divWork[DIV_W-1:BYTE_W]};
    end else begin : g_nopad
      assign rdHi = divWork[DIV_W-1:DIV_W-HI_W];
    end
  endgenerate

  // R2: the working divisor holds unless the lower register is written
  a_r2_hold_without_low_write: assert property (@(posedge clk) disable iff (rst)
    !wrLo |=> $stable(divWork));

  // R3: unimplemented readback bits stay zero across register traffic
  a_r3_pad_zero: assert property (@(posedge clk) disable iff (rst)
    wrHi |=> (rdHi[BYTE_W-1:HI_W] == '0));
endmodule

// File: rtl/baud_cnt.sv
module baud_cnt
  import baud_pkg::*;
#(
  parameter int DIV_W = 13,
  parameter int OVS   = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] divWork,
  input  cnt_ctl_t         ctl,
  output logic             ovsTick,
  output logic             bitTick
);
  localparam int PH_W = $clog2(OVS);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(OVS - 1);

  logic [DIV_W-1:0] preCnt;
  logic [PH_W-1:0]  phase;
  logic [DIV_W-1:0] termVal;
  logic             wrapNow;

  assign termVal = DIV_W'(divWork - 1'b1);
  // >= so a count left above a shrunken terminal wraps at once
  assign wrapNow = (preCnt >= termVal);

  always_ff @(posedge clk) begin
    if (rst || ctl.clear) begin
      preCnt  <= '0;
      phase   <= '0;
      ovsTick <= 1'b0;
      bitTick <= 1'b0;
    end else if (ctl.count) begin
      if (wrapNow) begin
        preCnt  <= '0;
        ovsTick <= 1'b1;
        if (phase == PH_LAST) begin
          phase   <= '0;
          bitTick <= 1'b1;
        end else begin
          phase   <= phase + 1'b1;
          bitTick <= 1'b0;
        end
      end else begin
        preCnt  <= preCnt + 1'b1;
        ovsTick <= 1'b0;
        bitTick <= 1'b0;
      end
    end
  end

  // R4 / R5: no pulse follows a cycle in which counting was not allowed
  a_r4_idle_no_tick: assert property (@(posedge clk) disable iff (rst)
    !ctl.count |=> (!ovsTick && !bitTick));

  // R7: a bit pulse always coincides with an oversample pulse
  a_r7_bit_on_ovs: assert property (@(posedge clk) disable iff (rst)
    bitTick |-> ovsTick);

  // R7: bit pulses are single-cycle
  a_r7_bit_single: assert property (@(posedge clk) disable iff (rst)
    bitTick |=> !bitTick);

  // R9: under a steady divisor the prescale count never exceeds its period
  a_r9_no_overlong: assert property (@(posedge clk) disable iff (rst)
    (ctl.count && $past(ctl.count) && $stable(divWork)) |-> (preCnt < divWork));
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_pkg::*;
#(
  parameter int DIV_W   = 13,
  parameter int BYTE_W  = 8,
  parameter int OVS     = 16,
  parameter int RST_DIV = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              wrHi,
  input  logic              wrLo,
  input  logic              rxEn,
  input  logic              txEn,
  output logic [BYTE_W-1:0] rdHi,
  output logic [BYTE_W-1:0] rdLo,
  output logic              ovsTick,
  output logic              bitTick
);
  logic [DIV_W-1:0] divWork;
  cnt_ctl_t         ctl;

  baud_ctrl #(.DIV_W(DIV_W), .BYTE_W(BYTE_W), .RST_DIV(RST_DIV)) u_ctrl (
    .clk(clk), .rst(rst), .wrData(wrData), .wrHi(wrHi), .wrLo(wrLo),
    .rxEn(rxEn), .txEn(txEn), .divWork(divWork), .ctl(ctl),
    .rdHi(rdHi), .rdLo(rdLo)
  );

  baud_cnt #(.DIV_W(DIV_W), .OVS(OVS)) u_cnt (
    .clk(clk), .rst(rst), .divWork(divWork), .ctl(ctl),
    .ovsTick(ovsTick), .bitTick(bitTick)
  );
endmodule

// File: tb/baud_tick_gen_tb.sv
module baud_tick_gen_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] wrData = '0;
  logic       wrHi = 1'b0, wrLo = 1'b0, rxEn = 1'b0, txEn = 1'b0;
  logic [7:0] rdHi, rdLo;
  logic       ovsTick, bitTick;
  int nChecks = 0, nFails = 0;
  int strayBit = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  baud_tick_gen u_dut (
    .clk(clk), .rst(rst), .wrData(wrData), .wrHi(wrHi), .wrLo(wrLo),
    .rxEn(rxEn), .txEn(txEn), .rdHi(rdHi), .rdLo(rdLo),
    .ovsTick(ovsTick), .bitTick(bitTick)
  );

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic writeHi(logic [7:0] v);
    @(negedge clk); wrData = v; wrHi = 1'b1;
    @(negedge clk); wrHi = 1'b0;
  endtask

  task automatic writeLo(logic [7:0] v);
    @(negedge clk); wrData = v; wrLo = 1'b1;
    @(negedge clk); wrLo = 1'b0;
  endtask

  // Negedges until ovsTick is seen high, counting the one where it is seen
  task automatic waitOvs(output int n);
    n = 0;
    do begin
      @(negedge clk); n++;
      if (bitTick && !ovsTick) strayBit++;
    end while (!ovsTick && n < 20000);
  endtask

  // Count ticks seen over a window of negedges
  task automatic quietWindow(int len, output int ticks);
    ticks = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (ovsTick || bitTick) ticks++;
    end
  endtask

  task automatic testReset();
    int t;
    check("R1 rdHi after reset", rdHi, 8'h00);
    check("R1 rdLo after reset", rdLo, 8'h04);
    quietWindow(60, t);
    check("R1 R4 no ticks with enables low", t, 0);
  endtask

  task automatic testStaged();
    writeHi(8'h12);
    check("R2 rdHi unchanged after upper write", rdHi, 8'h00);
    check("R2 rdLo unchanged after upper write", rdLo, 8'h04);
    writeLo(8'h34);
    check("R2 rdHi after lower write", rdHi, 8'h12);
    check("R2 rdLo after lower write", rdLo, 8'h34);
    writeHi(8'hFF);
    check("R3 rdHi still old after staging 0xFF", rdHi, 8'h12);
    writeLo(8'h01);
    check("R3 rdHi pads zero", rdHi, 8'h1F);
    check("R3 rdLo", rdLo, 8'h01);
  endtask

  task automatic testZero();
    int t;
    writeHi(8'h00); writeLo(8'h00);
    @(negedge clk); rxEn = 1'b1; txEn = 1'b1;
    quietWindow(100, t);
    check("R5 zero divisor gives no ticks", t, 0);
    rxEn = 1'b0; txEn = 1'b0;
  endtask

  task automatic testPeriod();
    int n;
    writeHi(8'h00); writeLo(8'd5);
    @(negedge clk); txEn = 1'b1;
    waitOvs(n);
    check("R8 first ovsTick after enable, D=5", n, 5);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R6 ovsTick single cycle, D=5", ovsTick, 0);
      waitOvs(n);
      check("R6 ovsTick period D=5", n + 1, 5);
    end
    txEn = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R4 ticks stop after disable", ovsTick, 0);
  endtask

  task automatic testBit();
    int n, k;
    writeHi(8'h00); writeLo(8'd2);
    @(negedge clk); rxEn = 1'b1;
    k = 0;
    do begin waitOvs(n); k++; end while (!bitTick && k < 40);
    check("R8 first bitTick on 16th ovsTick, D=2", k, 16);
    k = 0;
    do begin waitOvs(n); k++; end while (!bitTick && k < 40);
    check("R7 bitTick every 16 ovsTicks, D=2", k, 16);
    check("R7 bitTick only with ovsTick", strayBit, 0);
    rxEn = 1'b0;
  endtask

  task automatic testDivOne();
    int n, hi;
    writeHi(8'h00); writeLo(8'd1);
    @(negedge clk); txEn = 1'b1;
    n = 0; hi = 0;
    do begin @(negedge clk); n++; if (ovsTick) hi++; end while (!bitTick && n < 100);
    check("R8 first bitTick after 16 cycles, D=1", n, 16);
    check("R6 ovsTick high every cycle, D=1", hi, 16);
    n = 0;
    do begin @(negedge clk); n++; end while (!bitTick && n < 100);
    check("R7 bit period 16 cycles, D=1", n, 16);
    txEn = 1'b0;
  endtask

  task automatic testRestart();
    int n;
    writeHi(8'h00); writeLo(8'd7);
    @(negedge clk); rxEn = 1'b1;
    waitOvs(n);
    repeat (3) @(negedge clk);
    rxEn = 1'b0;
    repeat (4) @(negedge clk);
    txEn = 1'b1;
    waitOvs(n);
    check("R8 restart from zero, D=7", n, 7);
    txEn = 1'b0;
  endtask

  task automatic testMax();
    int n;
    writeHi(8'h1F); writeLo(8'hFF);
    check("R3 rdHi at full scale", rdHi, 8'h1F);
    @(negedge clk); rxEn = 1'b1;
    waitOvs(n);
    check("R6 first ovsTick, D=8191", n, 8191);
    waitOvs(n);
    check("R6 ovsTick period D=8191", n, 8191);
    rxEn = 1'b0;
  endtask

  task automatic testShrink();
    int n;
    writeHi(8'h00); writeLo(8'd20);
    @(negedge clk); rxEn = 1'b1;
    waitOvs(n);
    repeat (10) @(negedge clk);
    writeLo(8'd3);  // commits at the edge before the task returns
    waitOvs(n);
    check("R9 immediate wrap after shrink", n, 1);
    waitOvs(n);
    check("R9 new period after shrink", n, 3);
    rxEn = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    testReset();
    testStaged();
    testZero();
    testPeriod();
    testBit();
    testDivOne();
    testRestart();
    testMax();
    testShrink();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule